// File: doc/BRIEF.md
# Period-Match Timer with Programmable Postscaler

This block is an 8-bit interval timer for a microcontroller-style subsystem. The system clock is divided by four to form an instruction rate. A prescaler then divides that rate again by 1, 4 or 16, and the counter advances once per resulting tick. When the count equals a programmable period value, one match event is produced and the counter returns to zero on its next tick. Each period therefore lasts period+1 ticks.

Match events feed a postscaler whose divisor can be any integer from 1 to 16. When the programmed number of matches has been seen, a sticky flag is set. That flag is also the interrupt output. Software clears the flag, loads the period, zeroes the counter and sets the run bit. It then polls the flag to detect the end of the interval.

A small register port reaches the control byte, the counter, the period and the flag.

Top module: `period_timer`

## Requirements
- R1: After reset, control reads 8'h00, the counter reads 8'h00, the period reads 8'hFF and the flag is 0.
- R2: The prescale select sits in control bits 1:0. While running, a counter tick occurs every 4 system clocks for 2'b00, every 16 for 2'b01, and every 64 for 2'b10 and for 2'b11.
- R3: On a tick where the counter equals the period, the counter becomes 0; on any other tick it increments. One period is period+1 ticks.
- R4: The postscale field sits in control bits 6:3. A value N sets the flag on the (N+1)-th match after start. From a zeroed counter with run set, the flag is first high exactly prescale×(period+1)×(N+1) system clocks later.
- R5: The flag is sticky. Only a write to address 3 clears it, with any data.
- R6: If a match sets the flag in the same cycle as a clear write, the flag ends up set.
- R7: While the run bit (control bit 2) is 0, the counter holds its value and the flag is not set.
- R8: A write to control or to the counter zeroes the prescaler and postscaler counts, so the next tick comes a full prescale interval after the write.
- R9: Register map: address 0 is control (bit 7 reads 0), address 1 is the counter, address 2 is the period, and address 3 returns the flag in bit 0. irq_o equals the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Sticky expiry flag |

## Verification
The assertions assume that writes arrive as single-cycle strobes. They also assume that the counter is never loaded above the period while running; if it were, the counter would run past the period and through 255 before wrapping. The bench writes each register in its own cycle. It stops the timer and zeroes the counter before it loads a period, so the count always starts at or below the compare value. Every timed run starts from a cleared flag with the prescaler and postscaler freshly reset by the control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_PER  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  typedef struct packed {
    logic [3:0] post;
    logic       run;
    logic [1:0] pre;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PW-1:0] pre_q, term;

  // instruction divide (4) folded into prescale terminal count
  always_comb begin
    unique case (sel_i)
      2'b00:   term = PW'(3);
      2'b01:   term = PW'(15);
      default: term = PW'(63);
    endcase
  end

  assign tick_o = run_i && !clr_i && (pre_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] period_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o
);
  logic eq;
  assign eq      = (cnt_o == period_i);
  assign match_o = tick_i && !wr_i && eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wr_i)   cnt_o <= wdata_i;
    else if (tick_i) cnt_o <= eq ? '0 : cnt_o + 1'b1;
  end

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && eq) |=> (cnt_o == '0));
endmodule

// File: rtl/tmr_post.sv
module tmr_post #(
  parameter int PSW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           match_i,
  input  logic           clr_i,
  input  logic [PSW-1:0] div_i,
  input  logic           flag_clr_i,
  output logic           flag_o
);
  logic [PSW-1:0] post_q;
  logic           set;

  assign set = match_i && !clr_i && (post_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       post_q <= '0;
    else if (clr_i)    post_q <= '0;
    else if (match_i)  post_q <= set ? '0 : post_q + 1'b1;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (set)        flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  // R5
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set && flag_clr_i) |=> flag_o);
  // R4
  post_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && !clr_i) |=> $stable(post_q));
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] period_q, cnt;
  logic          wr_ctrl, wr_cnt, wr_per, wr_flag, scale_clr, tick, match, flag;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_cnt    = wr_en_i && (addr_i == A_CNT);
  assign wr_per    = wr_en_i && (addr_i == A_PER);
  assign wr_flag   = wr_en_i && (addr_i == A_FLAG);
  assign scale_clr = wr_ctrl || wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_t'(wdata_i[6:0]);
      if (wr_per)  period_q <= wdata_i;
    end
  end

  tmr_prescale #(.PW(6)) u_pre (
    .clk_i, .rst_ni, .run_i(ctrl_q.run), .clr_i(scale_clr),
    .sel_i(ctrl_q.pre), .tick_o(tick)
  );

  tmr_count #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .wr_i(wr_cnt), .wdata_i(wdata_i),
    .period_i(period_q), .cnt_o(cnt), .match_o(match)
  );

  tmr_post #(.PSW(4)) u_post (
    .clk_i, .rst_ni, .match_i(match), .clr_i(scale_clr),
    .div_i(ctrl_q.post), .flag_clr_i(wr_flag), .flag_o(flag)
  );

  assign irq_o = flag;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {1'b0, ctrl_q};
      A_CNT:   rdata_o = cnt;
      A_PER:   rdata_o = period_q;
      default: rdata_o = {7'b0, flag};
    endcase
  end

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_cnt) |=> $stable(cnt));
  // R7
  no_set_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !flag) |=> !flag);
endmodule

// File: tb/tb_period_timer.sv
module tb_period_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int checks = 0, fails = 0;

  localparam int NV = 6;
  localparam int V_PRE [NV] = '{0, 1, 0, 2, 3, 0};
  localparam int V_PS  [NV] = '{0, 2, 15, 1, 0, 7};
  localparam int V_PER [NV] = '{3, 2, 0, 1, 4, 5};

  period_timer dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr_i = a; #1; v = rdata_o;
  endtask

  function automatic int pre_div(int s);
    return (s == 0) ? 4 : (s == 1) ? 16 : 64;
  endfunction

  // stop, zero, load period, clear flag
  task automatic setup(int per);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'(per));
    bus_wr(2'd3, 8'h00);
  endtask

  function automatic logic [7:0] ctrl(int ps, int run, int pre);
    return {1'b0, 4'(ps), 1'(run), 2'(pre)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, t;
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 cnt", v, 0);
    rd(2'd2, v); check("R1 period", v, 255);
    check("R1 flag", irq_o, 0);

    // R2 R4 table
    for (int i = 0; i < NV; i++) begin
      setup(V_PER[i]);
      t = pre_div(V_PRE[i]) * (V_PER[i] + 1) * (V_PS[i] + 1);
      bus_wr(2'd0, ctrl(V_PS[i], 1, V_PRE[i]));
      step(t - 1);
      check("R4 flag before expiry", irq_o, 0);
      step(1);
      check("R2 R4 flag at expiry", irq_o, 1);
      rd(2'd1, v); check("R3 cnt wrapped at expiry", v, 0);
    end

    // R3 wrap
    setup(2);
    bus_wr(2'd0, ctrl(15, 1, 0));
    step(8);  rd(2'd1, v); check("R3 cnt at tick 2", v, 2);
    step(4);  rd(2'd1, v); check("R3 cnt wraps", v, 0);

    // R6 set wins, R5 clear
    setup(0);
    bus_wr(2'd0, ctrl(0, 1, 0));
    step(4); check("R4 first match", irq_o, 1);
    step(3);
    bus_wr(2'd3, 8'h00);
    check("R6 set wins", irq_o, 1);
    bus_wr(2'd3, 8'h00);
    check("R5 clear", irq_o, 0);
    rd(2'd3, v); check("R9 flag read", v, 0);

    // R5 sticky
    setup(0);
    bus_wr(2'd0, ctrl(0, 1, 0));
    step(4);
    bus_wr(2'd0, ctrl(0, 0, 0));
    step(40); check("R5 sticky", irq_o, 1);
    rd(2'd3, v); check("R9 flag bit0", v, 1);

    // R7 hold
    setup(200);
    bus_wr(2'd0, ctrl(0, 1, 0));
    step(10); rd(2'd1, v); check("R7 cnt running", v, 2);
    bus_wr(2'd0, ctrl(0, 0, 0));
    step(20); rd(2'd1, v); check("R7 cnt held", v, 2);
    check("R7 no flag", irq_o, 0);

    // R8 counter write resets prescaler
    setup(200);
    bus_wr(2'd0, ctrl(0, 1, 0));
    step(1);
    bus_wr(2'd1, 8'd5);
    step(3); rd(2'd1, v); check("R8 no early tick", v, 5);
    step(1); rd(2'd1, v); check("R8 tick after full interval", v, 6);

    // R9 map
    bus_wr(2'd0, 8'h83);
    rd(2'd0, v); check("R9 ctrl bit7 zero", v, 3);
    bus_wr(2'd2, 8'h5A);
    rd(2'd2, v); check("R9 period", v, 90);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule